// File: doc/BRIEF.md
# Four-Channel Tap Command Executor

This block turns 24-bit command words, already assembled by a serial shifter, into actions on four channels. Each channel holds an 8-bit tap setting and one output-mode bit. Some commands act directly on a channel's registers: a direct tap write, a one-step increment or decrement that stops at the ends of the range, and a read of the tap. Other commands become single requests to a separate non-volatile slot controller: load a slot into a channel, program a slot, store the present tap into a slot, erase a slot, or read a slot. The controller answers each request with exactly one response pulse. For loads and reads, that pulse carries the stored 9-bit word.

The block starts out by reloading every channel from slot 0, and it then sits dormant. While dormant it acts on nothing but the wake command. A software reset opcode repeats the same reload and leaves the block dormant again. The two read commands produce a 24-bit read-back word for the shifter. Its upper byte echoes the opcode and address bits of the read command, and its low 9 bits carry the value.

Top module: `tapcmd_exec`

## Requirements
- R1: Command fields sit at fixed positions: opcode in bits 23:20, slot in 19:18, channel in 17:16, 9-bit data in 8:0 with the mode bit at bit 8. The opcodes are: 0000 no-op, 0001 wake, 0010 program slot with data, 0011 store tap into slot, 0100 write tap, 0111 increment, 1000 sleep, 1001 software reset, 1010 read slot, 1011 load slot into tap, 1100 read tap, 1101 erase slot, 1111 decrement.
- R2: A write-tap command loads data bits 7:0 into the addressed channel's tap and leaves its mode bit unchanged.
- R3: Increment adds one to the addressed tap, and a tap at 255 stays at 255.
- R4: Decrement subtracts one from the addressed tap, and a tap at 0 stays at 0.
- R5: A channel's mode bit changes only when a slot word is loaded into that channel. The load sets {mode, tap} to the 9-bit response data.
- R6: After reset the block issues four slot requests, one after another: operation code 0 (read), slot 0, channels 0, 1, 2 and 3 in that order. It loads each response into its channel and then ends dormant, with `dormant` high from reset onward.
- R7: While dormant, every command except wake is ignored. Wake clears `dormant`, and sleep sets it.
- R8: A software-reset command reloads all channels from slot 0, as in R6, and leaves the block dormant.
- R9: One cycle after a read-tap command is accepted, `rdback_valid` pulses and `rdback_word` = {command bits 23:16, seven zeros, mode, tap} of the addressed channel.
- R10: A read-slot command issues a read request (operation code 0). When the response arrives, `rdback_word` = {command bits 23:16, seven zeros, response data}, and `rdback_valid` pulses.
- R11: Program-slot issues a write request (operation code 1) carrying data bits 8:0. Store-tap issues a write request carrying the channel's {mode, tap}. Erase issues operation code 2. All three carry the addressed channel and slot.
- R12: A command that arrives while `nv_busy` is high, or while a slot request is still awaiting its response, is dropped.
- R13: A no-op changes no tap or mode, issues no slot request and produces no read-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, acts as power-up |
| cmd_valid | input | 1 | One-cycle strobe for a complete command word |
| cmd_word | input | 24 | Command word |
| nv_busy | input | 1 | Slot controller cannot take a request |
| nv_rsp_valid | input | 1 | One-cycle response to the outstanding request |
| nv_rsp_data | input | 9 | Stored word returned for reads and loads |
| nv_req_valid | output | 1 | One-cycle slot request strobe |
| nv_req_op | output | 2 | 0 read, 1 write, 2 erase |
| nv_req_chan | output | 2 | Channel of the request |
| nv_req_slot | output | 2 | Slot of the request |
| nv_req_data | output | 9 | Word to be written |
| tap_out | output | 32 | Tap settings, channel n in bits 8n+7:8n |
| mode_out | output | 4 | Output-mode bit per channel |
| rdback_valid | output | 1 | Read-back word is valid this cycle |
| rdback_word | output | 24 | Read-back word for the shifter |
| dormant | output | 1 | Block is asleep or still reloading |

## Verification
The assertions watch, on every cycle, the properties that are local in time. A tap never moves past 255 on increment or below 0 on decrement. A mode bit never changes without a load. No step happens while dormant. Slot requests appear only when the controller is idle, never on two cycles in a row, and the reload always ends dormant. Only the bench's scenarios can show that the values are right end to end. These cover the order and content of the reload requests, the read-back word for both kinds of read, the data sent with program and store, the loss of commands sent back to back or during busy, and agreement with a reference model over a long random command stream.

// File: rtl/tapcmd_pkg.sv
package tapcmd_pkg;
  localparam int NCH    = 4;
  localparam int NSLOT  = 4;
  localparam int TAP_W  = 8;
  localparam int CH_W   = $clog2(NCH);
  localparam int SL_W   = $clog2(NSLOT);
  localparam int WORD_W = TAP_W + 1;
  localparam int OPC_W  = 4;
  localparam int HDR_W  = OPC_W + SL_W + CH_W;
  localparam int CMD_W  = 24;
  localparam int PAD_W  = CMD_W - HDR_W - WORD_W;

  typedef enum logic [OPC_W-1:0] {
    OP_NOP    = 4'h0,
    OP_WAKE   = 4'h1,
    OP_PROG   = 4'h2,
    OP_STORE  = 4'h3,
    OP_WRITE  = 4'h4,
    OP_INC    = 4'h7,
    OP_SLEEP  = 4'h8,
    OP_RESET  = 4'h9,
    OP_RDSLOT = 4'hA,
    OP_LOAD   = 4'hB,
    OP_RDTAP  = 4'hC,
    OP_ERASE  = 4'hD,
    OP_DEC    = 4'hF
  } opc_e;

  typedef enum logic [1:0] {
    NV_READ  = 2'd0,
    NV_WRITE = 2'd1,
    NV_ERASE = 2'd2
  } nvop_e;

  typedef enum logic [1:0] {
    PK_LOAD  = 2'd0,
    PK_READ  = 2'd1,
    PK_WRITE = 2'd2
  } pend_e;

  typedef struct packed {
    opc_e              op;
    logic [SL_W-1:0]   slot;
    logic [CH_W-1:0]   chan;
    logic [WORD_W-1:0] data;
    logic [HDR_W-1:0]  hdr;
  } cmd_t;

  function automatic logic [CMD_W-1:0] pack_rb(input logic [HDR_W-1:0] hdr,
                                               input logic [WORD_W-1:0] val);
    return {hdr, {PAD_W{1'b0}}, val};
  endfunction
endpackage

// File: rtl/tapcmd_decode.sv
module tapcmd_decode
  import tapcmd_pkg::*;
(
  input  logic [CMD_W-1:0] word,
  output cmd_t             cmd
);
  localparam int OP_LSB = CMD_W - OPC_W;
  localparam int SL_LSB = OP_LSB - SL_W;
  localparam int CH_LSB = SL_LSB - CH_W;

  always_comb begin
    cmd.op   = opc_e'(word[CMD_W-1 -: OPC_W]);
    cmd.slot = word[SL_LSB +: SL_W];
    cmd.chan = word[CH_LSB +: CH_W];
    cmd.data = word[WORD_W-1:0];
    cmd.hdr  = word[CMD_W-1 -: HDR_W];
  end
endmodule

// File: rtl/tapcmd_chan.sv
module tapcmd_chan
  import tapcmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [TAP_W-1:0]  wr_val,
  input  logic              inc_en,
  input  logic              dec_en,
  input  logic              ld_en,
  input  logic [WORD_W-1:0] ld_val,
  output logic [TAP_W-1:0]  tap,
  output logic              mode
);
  localparam logic [TAP_W-1:0] TOP = '1;

  function automatic logic [TAP_W-1:0] step_up(input logic [TAP_W-1:0] v);
    return (v == TOP) ? v : v + 1'b1;
  endfunction

  function automatic logic [TAP_W-1:0] step_down(input logic [TAP_W-1:0] v);
    return (v == '0) ? v : v - 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap  <= '0;
      mode <= 1'b0;
    end else if (ld_en) begin
      {mode, tap} <= ld_val;
    end else if (wr_en) begin
      tap <= wr_val;
    end else if (inc_en) begin
      tap <= step_up(tap);
    end else if (dec_en) begin
      tap <= step_down(tap);
    end
  end

  AST_INC_HOLDS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_en && !ld_en && !wr_en && tap == TOP) |=> tap == TOP); // R3
  AST_DEC_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_en && !ld_en && !wr_en && tap == '0) |=> tap == '0); // R4
  AST_MODE_ONLY_BY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_en |=> mode == $past(mode)); // R5
  AST_WRITE_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ld_en) |=> tap == $past(wr_val)); // R2
endmodule

// File: rtl/tapcmd_seq.sv
module tapcmd_seq
  import tapcmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  cmd_t              cmd,
  input  logic              nv_busy,
  input  logic              nv_rsp_valid,
  input  logic [WORD_W-1:0] nv_rsp_data,
  input  logic [WORD_W-1:0] sel_word,
  output logic [CH_W-1:0]   ctl_chan,
  output logic              ctl_write,
  output logic              ctl_inc,
  output logic              ctl_dec,
  output logic              ctl_load,
  output logic              nv_req_valid,
  output nvop_e             nv_req_op,
  output logic [CH_W-1:0]   nv_req_chan,
  output logic [SL_W-1:0]   nv_req_slot,
  output logic [WORD_W-1:0] nv_req_data,
  output logic              rb_valid,
  output logic [CMD_W-1:0]  rb_word,
  output logic              dormant
);
  logic            booting;
  logic [CH_W-1:0] boot_idx;
  logic            pending;
  pend_e           pend_kind;
  logic [CH_W-1:0] pend_chan;
  logic [HDR_W-1:0] pend_hdr;

  logic accept, act, rsp_take, boot_issue;

  assign accept     = cmd_valid && !booting && !pending && !nv_busy;
  assign act        = accept && (!dormant || cmd.op == OP_WAKE);
  assign rsp_take   = pending && nv_rsp_valid;
  assign boot_issue = booting && !pending && !nv_busy;

  assign ctl_write = act && cmd.op == OP_WRITE;
  assign ctl_inc   = act && cmd.op == OP_INC;
  assign ctl_dec   = act && cmd.op == OP_DEC;
  assign ctl_load  = rsp_take && pend_kind == PK_LOAD;
  assign ctl_chan  = ctl_load ? pend_chan : cmd.chan;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      booting      <= 1'b1;
      boot_idx     <= '0;
      pending      <= 1'b0;
      pend_kind    <= PK_LOAD;
      pend_chan    <= '0;
      pend_hdr     <= '0;
      dormant      <= 1'b1;
      nv_req_valid <= 1'b0;
      nv_req_op    <= NV_READ;
      nv_req_chan  <= '0;
      nv_req_slot  <= '0;
      nv_req_data  <= '0;
      rb_valid     <= 1'b0;
      rb_word      <= '0;
    end else begin
      nv_req_valid <= 1'b0;
      rb_valid     <= 1'b0;
      if (rsp_take) begin
        pending <= 1'b0;
        if (pend_kind == PK_READ) begin
          rb_valid <= 1'b1;
          rb_word  <= pack_rb(pend_hdr, nv_rsp_data);
        end
        if (booting) begin
          if (boot_idx == CH_W'(NCH - 1)) booting <= 1'b0;
          else                            boot_idx <= boot_idx + 1'b1;
        end
      end else if (boot_issue) begin
        pending      <= 1'b1;
        pend_kind    <= PK_LOAD;
        pend_chan    <= boot_idx;
        nv_req_valid <= 1'b1;
        nv_req_op    <= NV_READ;
        nv_req_chan  <= boot_idx;
        nv_req_slot  <= '0;
      end else if (act) begin
        pend_chan   <= cmd.chan;
        pend_hdr    <= cmd.hdr;
        nv_req_chan <= cmd.chan;
        nv_req_slot <= cmd.slot;
        unique case (cmd.op)
          OP_WAKE:  dormant <= 1'b0;
          OP_SLEEP: dormant <= 1'b1;
          OP_RESET: begin
            dormant  <= 1'b1;
            booting  <= 1'b1;
            boot_idx <= '0;
          end
          OP_RDTAP: begin
            rb_valid <= 1'b1;
            rb_word  <= pack_rb(cmd.hdr, sel_word);
          end
          OP_RDSLOT, OP_LOAD: begin
            pending      <= 1'b1;
            pend_kind    <= (cmd.op == OP_LOAD) ? PK_LOAD : PK_READ;
            nv_req_valid <= 1'b1;
            nv_req_op    <= NV_READ;
          end
          OP_PROG, OP_STORE: begin
            pending      <= 1'b1;
            pend_kind    <= PK_WRITE;
            nv_req_valid <= 1'b1;
            nv_req_op    <= NV_WRITE;
            nv_req_data  <= (cmd.op == OP_PROG) ? cmd.data : sel_word;
          end
          OP_ERASE: begin
            pending      <= 1'b1;
            pend_kind    <= PK_WRITE;
            nv_req_valid <= 1'b1;
            nv_req_op    <= NV_ERASE;
          end
          default: ;
        endcase
      end
    end
  end

  AST_ASLEEP_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (dormant && !(cmd_valid && cmd.op == OP_WAKE)) |-> !(ctl_write || ctl_inc || ctl_dec)); // R7
  AST_REQ_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nv_req_valid) |-> !$past(nv_busy)); // R12
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    nv_req_valid |=> !nv_req_valid); // R12
  AST_BOOT_ENDS_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(booting) |-> dormant); // R6
endmodule

// File: rtl/tapcmd_exec.sv
module tapcmd_exec
  import tapcmd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [23:0]          cmd_word,
  input  logic                 nv_busy,
  input  logic                 nv_rsp_valid,
  input  logic [8:0]           nv_rsp_data,
  output logic                 nv_req_valid,
  output logic [1:0]           nv_req_op,
  output logic [1:0]           nv_req_chan,
  output logic [1:0]           nv_req_slot,
  output logic [8:0]           nv_req_data,
  output logic [31:0]          tap_out,
  output logic [3:0]           mode_out,
  output logic                 rdback_valid,
  output logic [23:0]          rdback_word,
  output logic                 dormant
);
  cmd_t              cmd;
  logic [CH_W-1:0]   ctl_chan;
  logic              ctl_write, ctl_inc, ctl_dec, ctl_load;
  logic [WORD_W-1:0] sel_word;
  nvop_e             req_op;
  logic [TAP_W-1:0]  tap_arr  [NCH];
  logic              mode_arr [NCH];

  tapcmd_decode u_dec (
    .word (cmd_word),
    .cmd  (cmd)
  );

  tapcmd_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd          (cmd),
    .nv_busy      (nv_busy),
    .nv_rsp_valid (nv_rsp_valid),
    .nv_rsp_data  (nv_rsp_data),
    .sel_word     (sel_word),
    .ctl_chan     (ctl_chan),
    .ctl_write    (ctl_write),
    .ctl_inc      (ctl_inc),
    .ctl_dec      (ctl_dec),
    .ctl_load     (ctl_load),
    .nv_req_valid (nv_req_valid),
    .nv_req_op    (req_op),
    .nv_req_chan  (nv_req_chan),
    .nv_req_slot  (nv_req_slot),
    .nv_req_data  (nv_req_data),
    .rb_valid     (rdback_valid),
    .rb_word      (rdback_word),
    .dormant      (dormant)
  );

  assign nv_req_op = req_op;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic hit;
    assign hit = (ctl_chan == CH_W'(i));
    tapcmd_chan u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (ctl_write && hit),
      .wr_val (cmd.data[TAP_W-1:0]),
      .inc_en (ctl_inc && hit),
      .dec_en (ctl_dec && hit),
      .ld_en  (ctl_load && hit),
      .ld_val (nv_rsp_data),
      .tap    (tap_arr[i]),
      .mode   (mode_arr[i])
    );
    assign tap_out[i*TAP_W +: TAP_W] = tap_arr[i];
    assign mode_out[i]               = mode_arr[i];
  end

  assign sel_word = {mode_arr[cmd.chan], tap_arr[cmd.chan]};
endmodule

// File: tb/sim_tapcmd_exec.sv
module sim_tapcmd_exec;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [23:0] cmd_word = '0;
  logic        nv_busy;
  logic        nv_rsp_valid = 1'b0;
  logic [8:0]  nv_rsp_data;
  logic        nv_req_valid;
  logic [1:0]  nv_req_op, nv_req_chan, nv_req_slot;
  logic [8:0]  nv_req_data;
  logic [31:0] tap_out;
  logic [3:0]  mode_out;
  logic        rdback_valid;
  logic [23:0] rdback_word;
  logic        dormant;

  always #(CLK_NS/2) clk = ~clk;

  tapcmd_exec u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .nv_busy(nv_busy), .nv_rsp_valid(nv_rsp_valid), .nv_rsp_data(nv_rsp_data),
    .nv_req_valid(nv_req_valid), .nv_req_op(nv_req_op), .nv_req_chan(nv_req_chan),
    .nv_req_slot(nv_req_slot), .nv_req_data(nv_req_data), .tap_out(tap_out),
    .mode_out(mode_out), .rdback_valid(rdback_valid), .rdback_word(rdback_word),
    .dormant(dormant)
  );

  int n_chk = 0;
  int n_bad = 0;

  // slot controller model
  logic [8:0] mem [16];
  logic       mbusy = 1'b0;
  logic       hold_busy = 1'b0;
  logic [3:0] mcnt = '0;
  logic [8:0] mdata = '0;
  int         rq_cnt = 0;
  int         rb_cnt = 0;
  logic [5:0] req_log [4];
  logic [1:0] lq_op, lq_ch, lq_sl;
  logic [8:0] lq_data;
  logic [23:0] rb_last = '0;

  assign nv_busy     = mbusy | hold_busy;
  assign nv_rsp_data = mdata;

  always @(negedge clk) begin
    nv_rsp_valid <= 1'b0;
    if (rdback_valid) begin
      rb_cnt  <= rb_cnt + 1;
      rb_last <= rdback_word;
    end
    if (mcnt != 0) begin
      mcnt <= mcnt - 1'b1;
      if (mcnt == 1) begin
        nv_rsp_valid <= 1'b1;
        mbusy        <= 1'b0;
      end
    end else if (nv_req_valid) begin
      mbusy   <= 1'b1;
      mcnt    <= 4'd3;
      rq_cnt  <= rq_cnt + 1;
      lq_op   <= nv_req_op;
      lq_ch   <= nv_req_chan;
      lq_sl   <= nv_req_slot;
      lq_data <= nv_req_data;
      if (rq_cnt < 4) req_log[rq_cnt] <= {nv_req_op, nv_req_slot, nv_req_chan};
      case (nv_req_op)
        2'd0: mdata <= mem[{nv_req_chan, nv_req_slot}];
        2'd1: mem[{nv_req_chan, nv_req_slot}] <= nv_req_data;
        2'd2: mem[{nv_req_chan, nv_req_slot}] <= 9'h1FF;
        default: ;
      endcase
    end
  end

  logic [7:0] exp_tap [4];
  logic       exp_mode [4];

  function automatic logic [7:0] bump(input logic [7:0] v, input bit up);
    if (up) return (v == 8'd255) ? 8'd255 : v + 8'd1;
    return (v == 8'd0) ? 8'd0 : v - 8'd1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_taps(input string req);
    for (int i = 0; i < 4; i++) begin
      chk(req, {24'd0, tap_out[i*8 +: 8]}, {24'd0, exp_tap[i]});
      chk(req, {31'd0, mode_out[i]}, {31'd0, exp_mode[i]});
    end
  endtask

  task automatic send(input logic [3:0] op, input logic [1:0] sl, input logic [1:0] ch,
                      input logic [8:0] d, input logic [6:0] pad);
    @(negedge clk);
    cmd_word  = {op, sl, ch, pad, d};
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic load_exp_from_slot0();
    for (int i = 0; i < 4; i++) {exp_mode[i], exp_tap[i]} = mem[i*4];
  endtask

  // awake command with reference-model update and checks
  task automatic do_cmd(input logic [3:0] op, input logic [1:0] sl, input logic [1:0] ch,
                        input logic [8:0] d, input logic [6:0] pad);
    int rb0, rq0;
    logic [8:0] cur, sv;
    rb0 = rb_cnt;
    rq0 = rq_cnt;
    cur = {exp_mode[ch], exp_tap[ch]};
    sv  = mem[{ch, sl}];
    send(op, sl, ch, d, pad);
    case (op)
      4'h4: exp_tap[ch] = d[7:0];
      4'h7: exp_tap[ch] = bump(exp_tap[ch], 1'b1);
      4'hF: exp_tap[ch] = bump(exp_tap[ch], 1'b0);
      4'hB: {exp_mode[ch], exp_tap[ch]} = sv;
      4'h2: begin
        chk("R11 prog op", {30'd0, lq_op}, 32'd1);
        chk("R11 prog data", {23'd0, lq_data}, {23'd0, d});
        chk("R1 prog addr", {28'd0, lq_ch, lq_sl}, {28'd0, ch, sl});
      end
      4'h3: begin
        chk("R11 store op", {30'd0, lq_op}, 32'd1);
        chk("R11 store data", {23'd0, lq_data}, {23'd0, cur});
      end
      4'hD: begin
        chk("R11 erase op", {30'd0, lq_op}, 32'd2);
        chk("R11 erase addr", {28'd0, lq_ch, lq_sl}, {28'd0, ch, sl});
      end
      4'hC: begin
        chk("R9 rdtap count", rb_cnt, rb0 + 1);
        chk("R9 rdtap word", {8'd0, rb_last}, {8'd0, op, sl, ch, 7'd0, cur});
      end
      4'hA: begin
        chk("R10 rdslot count", rb_cnt, rb0 + 1);
        chk("R10 rdslot word", {8'd0, rb_last}, {8'd0, op, sl, ch, 7'd0, sv});
      end
      4'h0: begin
        chk("R13 nop no request", rq_cnt, rq0);
        chk("R13 nop no readback", rb_cnt, rb0);
      end
      default: ;
    endcase
    chk_taps("R1 channel state");
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    logic [3:0] ops [10];
    int rb0;
    void'($urandom(32'd4711));
    for (int i = 0; i < 16; i++) mem[i] = 9'($urandom);
    ops = '{4'h0, 4'h2, 4'h3, 4'h4, 4'h7, 4'hA, 4'hB, 4'hC, 4'hD, 4'hF};

    // reset state (R6)
    repeat (3) @(negedge clk);
    chk("R6 reset dormant", {31'd0, dormant}, 32'd1);
    chk("R6 reset no request", {31'd0, nv_req_valid}, 32'd0);
    chk("R9 reset no readback", {31'd0, rdback_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (60) @(negedge clk);
    load_exp_from_slot0();
    chk_taps("R6 boot reload");
    chk("R6 boot dormant", {31'd0, dormant}, 32'd1);
    chk("R6 boot request count", rq_cnt, 4);
    for (int i = 0; i < 4; i++)
      chk("R6 boot request order", {26'd0, req_log[i]}, {26'd0, 2'd0, 2'd0, 2'(i)});

    // asleep: ignored commands (R7)
    rb0 = rb_cnt;
    send(4'h4, 2'd0, 2'd0, 9'h055, 7'd0);
    send(4'h7, 2'd0, 2'd1, 9'h000, 7'd0);
    send(4'hB, 2'd1, 2'd2, 9'h000, 7'd0);
    send(4'hC, 2'd0, 2'd0, 9'h000, 7'd0);
    chk_taps("R7 asleep ignores");
    chk("R7 asleep no readback", rb_cnt, rb0);
    chk("R7 asleep no request", rq_cnt, 4);
    send(4'h1, 2'd0, 2'd0, 9'h000, 7'd0);
    chk("R7 wake clears dormant", {31'd0, dormant}, 32'd0);

    // saturation and direct write (R2 R3 R4)
    do_cmd(4'h4, 2'd0, 2'd1, 9'h0FE, 7'd0);
    do_cmd(4'h7, 2'd0, 2'd1, 9'h000, 7'd0);
    do_cmd(4'h7, 2'd0, 2'd1, 9'h000, 7'd0);
    chk("R3 increment stops at 255", {24'd0, tap_out[15:8]}, 32'd255);
    do_cmd(4'h4, 2'd0, 2'd2, 9'h001, 7'd0);
    do_cmd(4'hF, 2'd0, 2'd2, 9'h000, 7'd0);
    do_cmd(4'hF, 2'd0, 2'd2, 9'h000, 7'd0);
    chk("R4 decrement stops at 0", {24'd0, tap_out[23:16]}, 32'd0);
    exp_mode[3] = mode_out[3];
    do_cmd(4'h4, 2'd0, 2'd3, {~mode_out[3], 8'hAA}, 7'd0);
    chk("R2 write keeps mode", {31'd0, mode_out[3]}, {31'd0, exp_mode[3]});

    // slot program, load, reads (R5 R9 R10 R11)
    do_cmd(4'hD, 2'd3, 2'd0, 9'h000, 7'd0);
    do_cmd(4'h2, 2'd3, 2'd0, {~mode_out[0], 8'hC3}, 7'd0);
    do_cmd(4'hB, 2'd3, 2'd0, 9'h000, 7'd0);
    chk("R5 load sets mode", {31'd0, mode_out[0]}, {31'd0, mem[3][8]});
    do_cmd(4'hA, 2'd3, 2'd0, 9'h000, 7'd0);
    do_cmd(4'hC, 2'd0, 2'd0, 9'h000, 7'd0);
    do_cmd(4'h3, 2'd2, 2'd1, 9'h000, 7'd0);
    do_cmd(4'h0, 2'd0, 2'd0, 9'h000, 7'd0);

    // dropped commands (R12)
    hold_busy = 1'b1;
    send(4'h4, 2'd0, 2'd0, 9'h011, 7'd0);
    hold_busy = 1'b0;
    chk_taps("R12 busy drops write");
    @(negedge clk);
    cmd_word = {4'hA, 2'd1, 2'd1, 7'd0, 9'd0};
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_word = {4'h4, 2'd0, 2'd2, 7'd0, 9'h0E7};
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (10) @(negedge clk);
    chk_taps("R12 back-to-back drop");

    // random stream (R1)
    for (int k = 0; k < 250; k++) begin
      logic [8:0] d;
      d = 9'($urandom);
      if ($urandom_range(3) == 0) d[7:0] = $urandom_range(1) ? 8'hFF : 8'h00;
      do_cmd(ops[$urandom_range(9)], 2'($urandom), 2'($urandom), d, 7'($urandom));
    end

    // sleep then software reset (R7 R8)
    send(4'h8, 2'd0, 2'd0, 9'h000, 7'd0);
    chk("R7 sleep sets dormant", {31'd0, dormant}, 32'd1);
    send(4'h4, 2'd0, 2'd0, 9'h099, 7'd0);
    chk_taps("R7 sleep ignores write");
    send(4'h1, 2'd0, 2'd0, 9'h000, 7'd0);
    do_cmd(4'h4, 2'd0, 2'd0, 9'h03C, 7'd0);
    send(4'h9, 2'd0, 2'd0, 9'h000, 7'd0);
    repeat (60) @(negedge clk);
    load_exp_from_slot0();
    chk_taps("R8 software reset reload");
    chk("R8 ends dormant", {31'd0, dormant}, 32'd1);

    finish_run();
  end
endmodule